// File: doc/BRIEF.md
# Dual-Core Prioritized Interrupt Scheduler

This block gathers hardware interrupt lines and a small bank of software-raised requests into a single source space and schedules them onto two processor cores. Each source carries a programmable priority and a two-bit routing field. The routing field can send the source to either core, to both cores, or to neither. Each core has its own arbiter, vector register, acknowledge handling and nesting stack. Because the two paths share nothing but configuration, one core's servicing never holds up the other.

A core takes an interrupt by pulsing its acknowledge while its request is high. The scheduler then saves the core's current mask on a per-core stack and raises the mask to the priority of the taken source. Only strictly higher priorities can preempt after that. An end-of-interrupt pulse restores the saved mask. Software may also write a core's mask directly to raise its level while it holds a shared resource. Software requests let one core interrupt the other, and let a handler defer the rest of its work to a lower priority.

Top module: `dual_irq_sched`

## Requirements
- R1: After a synchronous reset, both request outputs are low, both masks read 0, every source configuration reads 0 and all software request bits read 0.
- R2: A source whose priority field is 0 never causes a request on either core.
- R3: The configuration word of source i is written at address i. Bits [3:0] hold the priority, bit 4 routes the source to core 0 and bit 5 routes it to core 1. With both bits set, both cores are served, and a source with neither bit set reaches no core.
- R4: Among eligible pending sources, the highest priority wins, and a tie goes to the lowest index. The vector output is the winning index. Software bit k is source k, and hardware line k is source N_SW+k (8+k by default).
- R5: A source is eligible for a core only if its priority is strictly greater than that core's mask. The mask of core c is written and read at address N_SRC+c (316 and 317 by default).
- R6: An acknowledge while the request is high pushes the core's mask onto its stack and sets the mask to the vector's priority. The request is low in the cycle after the acknowledge. Afterwards, only a strictly higher priority raises the request again, which is preemption.
- R7: An end-of-interrupt pulse pops the stack into the mask. When the stack is empty, the pulse leaves the mask unchanged.
- R8: At address N_SRC+2 (318 by default), writing 1s to data bits [7:0] sets software bits and writing 1s to data bits [15:8] clears them. When both fields name the same bit in one write, the clear wins. Reading that address returns the bits in [7:0].
- R9: Acknowledge and end-of-interrupt on one core leave the other core's mask and request unaffected.
- R10: The request output is registered. A change on a hardware line is seen on the request after the next clock edge, and the vector is valid in every cycle in which the request is high.
- R11: An acknowledge pulse while the core's request is low is ignored and the mask is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Read data, registered one cycle after rd_addr |
| hw_irq | input | N_HW | Hardware interrupt lines, active high, level |
| irq_req | output | 2 | Per-core interrupt request |
| irq_vec | output | 2*VEC_W | Per-core vector, core 0 in the low VEC_W bits |
| irq_ack | input | 2 | Per-core acknowledge pulse |
| irq_eoi | input | 2 | Per-core end-of-interrupt pulse |

## Verification
The arbiter is driven with patterns that tell apart routing to one core, both cores or neither. Other patterns pit a higher priority against a lower one and put two equal priorities against each other, where index order must decide. A disabled source is pending beside enabled ones, and the mask is set at, below and above the pending priority, so that the strict comparison can be seen. Directed sequences nest two acknowledges, unwind them with end-of-interrupt pulses down to an empty stack, and pulse acknowledge with no request. They also watch the other core during the nesting, and raise and clear software bits, including a write that sets and clears the same bit at once.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int DATA_W = 32;
  localparam int NCORE  = 2;
endpackage

// File: rtl/dirq_cfg_regs.sv
module dirq_cfg_regs
  import dirq_pkg::*;
#(
  parameter int N_SRC  = 316,
  parameter int N_SW   = 8,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 9
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [NCORE-1:0][PRIO_W-1:0]  mask_in,
  output logic [NCORE-1:0]              mask_wr,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio,
  output logic [NCORE-1:0][N_SRC-1:0]   route,
  output logic [N_SW-1:0]               sw_bits
);
  localparam int A_MASK0 = N_SRC;
  localparam int A_SW    = N_SRC + NCORE;

  logic sw_wr;
  assign sw_wr = wr_en && (wr_addr == ADDR_W'(A_SW));

  for (genvar c = 0; c < NCORE; c++) begin : g_mwr
    assign mask_wr[c] = wr_en && (wr_addr == ADDR_W'(A_MASK0 + c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio  <= '0;
      route <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (wr_addr == ADDR_W'(i)) begin
          prio[i] <= wr_data[PRIO_W-1:0];
          for (int c = 0; c < NCORE; c++) route[c][i] <= wr_data[PRIO_W+c];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        sw_bits <= '0;
    else if (sw_wr) sw_bits <= (sw_bits | wr_data[N_SW-1:0]) & ~wr_data[2*N_SW-1:N_SW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int i = 0; i < N_SRC; i++)
        if (rd_addr == ADDR_W'(i)) begin
          rd_data[PRIO_W-1:0] <= prio[i];
          for (int c = 0; c < NCORE; c++) rd_data[PRIO_W+c] <= route[c][i];
        end
      for (int c = 0; c < NCORE; c++)
        if (rd_addr == ADDR_W'(A_MASK0 + c)) rd_data[PRIO_W-1:0] <= mask_in[c];
      if (rd_addr == ADDR_W'(A_SW)) rd_data[N_SW-1:0] <= sw_bits;
    end
  end

  AST_SW_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> ((sw_bits & $past(wr_data[2*N_SW-1:N_SW])) == '0)); // R8
endmodule

// File: rtl/dirq_core_path.sv
module dirq_core_path #(
  parameter int N_SRC  = 316,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 16,
  parameter int VEC_W  = 9
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_SRC-1:0]             pend,
  input  logic [N_SRC-1:0]             en,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                         mask_wr,
  input  logic [PRIO_W-1:0]            mask_wdata,
  input  logic                         ack_i,
  input  logic                         eoi_i,
  output logic                         req_o,
  output logic [VEC_W-1:0]             vec_o,
  output logic [PRIO_W-1:0]            mask_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] mask_q, prio_q, best_p;
  logic [VEC_W-1:0]  best_i;
  logic              hit, req_q, take, pop;
  logic [CNT_W-1:0]  cnt;
  logic [PRIO_W-1:0] stk [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  always_comb begin
    best_p = '0;
    best_i = '0;
    hit    = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i] && en[i] && (prio[i] > mask_q) && (prio[i] >= best_p)) begin
        best_p = prio[i];
        best_i = VEC_W'(i);
        hit    = 1'b1;
      end
    end
  end

  assign take = ack_i && req_q;
  assign pop  = eoi_i && !take && (cnt != '0);
  assign wptr = PTR_W'(cnt);
  assign rptr = PTR_W'(cnt - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      vec_o  <= '0;
      prio_q <= '0;
    end else begin
      req_q  <= hit && !take;
      vec_o  <= best_i;
      prio_q <= best_p;
    end
  end

  always_ff @(posedge clk) begin
    if (take && (cnt < CNT_W'(DEPTH))) stk[wptr] <= mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cnt    <= '0;
    end else if (take) begin
      mask_q <= prio_q;
      if (cnt < CNT_W'(DEPTH)) cnt <= cnt + CNT_W'(1);
    end else if (pop) begin
      mask_q <= stk[rptr];
      cnt    <= cnt - CNT_W'(1);
    end else if (eoi_i) begin
      mask_q <= mask_q;
    end else if (mask_wr) begin
      mask_q <= mask_wdata;
    end
  end

  assign req_o  = req_q;
  assign mask_o = mask_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    take |-> (cnt < CNT_W'(DEPTH))); // R6
  AST_MASK_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    take |=> (mask_q == $past(prio_q))); // R6
  AST_REQ_DROP_ACK: assert property (@(posedge clk) disable iff (rst)
    take |=> !req_q); // R6
  AST_REQ_PRIO_NZ: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (prio_q != '0)); // R2
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !take && (cnt == '0)) |=> $stable(mask_q)); // R7
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !req_q && !eoi_i && !mask_wr) |=> $stable(mask_q)); // R11
endmodule

// File: rtl/dual_irq_sched.sv
module dual_irq_sched
  import dirq_pkg::*;
#(
  parameter int N_HW   = 308,
  parameter int N_SW   = 8,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 16,
  localparam int N_SRC  = N_SW + N_HW,
  localparam int ADDR_W = $clog2(N_SRC + NCORE + 1),
  localparam int VEC_W  = $clog2(N_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [31:0]               rd_data,
  input  logic [N_HW-1:0]           hw_irq,
  output logic [1:0]                irq_req,
  output logic [2*VEC_W-1:0]        irq_vec,
  input  logic [1:0]                irq_ack,
  input  logic [1:0]                irq_eoi
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [NCORE-1:0][N_SRC-1:0]  route;
  logic [N_SW-1:0]              sw_bits;
  logic [NCORE-1:0][PRIO_W-1:0] mask;
  logic [NCORE-1:0]             mask_wr;
  logic [N_SRC-1:0]             pend;

  assign pend = {hw_irq, sw_bits};

  dirq_cfg_regs #(.N_SRC(N_SRC), .N_SW(N_SW), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mask_in(mask), .mask_wr(mask_wr),
    .prio(prio), .route(route), .sw_bits(sw_bits));

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    dirq_core_path #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .VEC_W(VEC_W)) path_i (
      .clk(clk), .rst(rst), .pend(pend), .en(route[c]), .prio(prio),
      .mask_wr(mask_wr[c]), .mask_wdata(wr_data[PRIO_W-1:0]),
      .ack_i(irq_ack[c]), .eoi_i(irq_eoi[c]),
      .req_o(irq_req[c]), .vec_o(irq_vec[c*VEC_W +: VEC_W]), .mask_o(mask[c]));
  end

  AST_OTHER_CORE_MASK: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !irq_ack[1] && !irq_eoi[1] && !mask_wr[1]) |=> $stable(mask[1])); // R9
endmodule

// File: tb/dual_irq_sched_tb_top.sv
module dual_irq_sched_tb_top;
  localparam int CLK_P  = 10;
  localparam int N_HW   = 308;
  localparam int N_SRC  = 316;
  localparam int ADDR_W = 9;
  localparam int VW     = 9;
  localparam int A_M0   = 316;
  localparam int A_M1   = 317;
  localparam int A_SW   = 318;
  localparam int NV     = 12;
  // {hw[15:0], mask0, req0, vec0, req1, vec1}
  localparam logic [39:0] TBL [NV] = '{
    {16'h0000, 4'd0, 1'b0, 9'd0,  1'b0, 9'd0},
    {16'h0001, 4'd0, 1'b1, 9'd8,  1'b0, 9'd0},
    {16'h0003, 4'd0, 1'b1, 9'd9,  1'b1, 9'd9},
    {16'h0006, 4'd0, 1'b1, 9'd9,  1'b1, 9'd9},
    {16'h0004, 4'd0, 1'b1, 9'd10, 1'b0, 9'd0},
    {16'h0008, 4'd0, 1'b0, 9'd0,  1'b1, 9'd11},
    {16'h0010, 4'd0, 1'b0, 9'd0,  1'b0, 9'd0},
    {16'h0020, 4'd0, 1'b0, 9'd0,  1'b0, 9'd0},
    {16'h0005, 4'd3, 1'b1, 9'd10, 1'b0, 9'd0},
    {16'h0001, 4'd3, 1'b0, 9'd0,  1'b0, 9'd0},
    {16'h000A, 4'd5, 1'b0, 9'd0,  1'b1, 9'd11},
    {16'h000C, 4'd4, 1'b1, 9'd10, 1'b1, 9'd11}
  };

  logic clk = 0, rst = 1, wr_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, v;
  logic [N_HW-1:0] hw_irq = '0;
  logic [1:0] irq_req, irq_ack = '0, irq_eoi = '0;
  logic [2*VW-1:0] irq_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_irq_sched dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hw_irq(hw_irq),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_eoi(irq_eoi));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask
  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    d = rd_data;
  endtask
  task automatic pulse_ack0();
    irq_ack[0] = 1; @(negedge clk); irq_ack[0] = 0;
  endtask
  task automatic pulse_eoi0();
    irq_eoi[0] = 1; @(negedge clk); irq_eoi[0] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3); rst = 0; tick(1);
    chk("R1 req", 32'(irq_req), 0);
    rd(A_M0, v); chk("R1 mask0", v, 0);
    rd(9, v);    chk("R1 cfg", v, 0);
    rd(A_SW, v); chk("R1 sw", v, 0);

    wr(8, 32'h13); wr(9, 32'h35); wr(10, 32'h15); wr(11, 32'h27);
    wr(12, 32'h30); wr(13, 32'h02); wr(1, 32'h39);
    rd(9, v); chk("R3 cfg fields", v, 32'h35);

    for (int e = 0; e < NV; e++) begin
      wr(A_M0, 32'(TBL[e][23:20]));
      hw_irq[15:0] = TBL[e][39:24];
      tick(2);
      chk("R4 R5 R3 R2 req0", 32'(irq_req[0]), 32'(TBL[e][19]));
      if (TBL[e][19]) chk("R4 vec0", 32'(irq_vec[VW-1:0]), 32'(TBL[e][18:10]));
      chk("R3 req1", 32'(irq_req[1]), 32'(TBL[e][9]));
      if (TBL[e][9]) chk("R4 vec1", 32'(irq_vec[2*VW-1:VW]), 32'(TBL[e][8:0]));
    end

    wr(A_M0, 0); hw_irq = '0; tick(2);
    hw_irq[0] = 1;
    chk("R10 before edge", 32'(irq_req[0]), 0);
    tick(1);
    chk("R10 after edge", 32'(irq_req[0]), 1);
    chk("R10 vec", 32'(irq_vec[VW-1:0]), 8);

    pulse_ack0();
    chk("R6 req drop", 32'(irq_req[0]), 0);
    rd(A_M0, v); chk("R6 mask after ack", v, 3);
    tick(1); chk("R6 no equal preempt", 32'(irq_req[0]), 0);
    hw_irq[1] = 1; tick(2);
    chk("R6 preempt req", 32'(irq_req[0]), 1);
    chk("R6 preempt vec", 32'(irq_vec[VW-1:0]), 9);
    pulse_ack0();
    rd(A_M0, v); chk("R6 nested mask", v, 5);
    chk("R9 core1 req", 32'(irq_req[1]), 1);
    rd(A_M1, v); chk("R9 core1 mask", v, 0);
    pulse_eoi0(); rd(A_M0, v); chk("R7 pop1", v, 3);
    pulse_eoi0(); rd(A_M0, v); chk("R7 pop2", v, 0);
    pulse_eoi0(); rd(A_M0, v); chk("R7 empty pop", v, 0);

    hw_irq = '0; tick(2);
    pulse_ack0(); rd(A_M0, v); chk("R11 idle ack", v, 0);

    wr(A_SW, 32'h0000_0002); rd(A_SW, v); chk("R8 set", v, 2);
    chk("R8 R4 sw req0", 32'(irq_req[0]), 1);
    chk("R8 R4 sw vec0", 32'(irq_vec[VW-1:0]), 1);
    chk("R8 R3 sw vec1", 32'(irq_vec[2*VW-1:VW]), 1);
    wr(A_SW, 32'h0000_0808); rd(A_SW, v); chk("R8 clear wins", v, 2);
    wr(A_SW, 32'h0000_0200); rd(A_SW, v); chk("R8 clear", v, 0);
    tick(1); chk("R8 req gone", 32'(irq_req), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule